// File: doc/BRIEF.md
# Bidirectional Parallel-Load Shift Register

This block keeps a word of configurable width (eight bits unless set otherwise). On each rising edge of the one system clock it does exactly one of four things: keeps its value, takes a whole new word from the parallel input, moves every bit one place toward the MSB, or moves every bit one place toward the LSB. The load and shift controls are synchronous enables. They never gate the clock. A serial input fills the end that the shift leaves empty.

The bit that leaves during a shift appears on a serial output. The serial output shows the MSB when the direction selects left and the LSB when it selects right, so it always shows the bit that the next shift in the current direction would push out. To chain two registers into one wide register, connect the serial output of one stage to the serial input of the next and drive both stages from the same shift and direction controls.

Top module: `bidir_shreg`

## Requirements
- R1: A synchronous active-high reset (`rst`=1 at a rising edge) clears `q` to all zeros. Reset takes priority over every other input.
- R2: With `loadEn`=0 and `shiftEn`=0, `q` keeps its value across the edge.
- R3: With `loadEn`=0, `shiftEn`=1 and `dirRight`=0 (left), the next `q` is `{q[W-2:0], serIn}`.
- R4: With `loadEn`=0, `shiftEn`=1 and `dirRight`=1 (right), the next `q` is `{serIn, q[W-1:1]}`.
- R5: With `loadEn`=1, the next `q` equals `parIn`, whatever `shiftEn`, `dirRight` and `serIn` are.
- R6: All bits update together from the values held before the edge. After W consecutive left shifts with `serIn` held at 1, the value is all ones, and each intermediate value has exactly one more 1 than the one before.
- R7: `serOut` is combinational. It equals `q[W-1]` when `dirRight`=0 and `q[0]` when `dirRight`=1.
- R8: Two stages can be chained for a right shift. If the upper stage's `serOut` drives the lower stage's `serIn` and both share `shiftEn` and `dirRight`, the pair behaves as one 2W-bit register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous active-high clear |
| loadEn | input | 1 | Parallel load enable (wins over shift) |
| shiftEn | input | 1 | Shift enable |
| dirRight | input | 1 | Direction: 0 = toward MSB, 1 = toward LSB |
| serIn | input | 1 | Bit that fills the vacated end |
| parIn | input | WIDTH | Parallel load word |
| q | output | WIDTH | Current register contents |
| serOut | output | 1 | Bit that leaves on a shift in the current direction |

## Verification
Shifts are tried with asymmetric words such as 8'hB6 and 8'h81, in both directions, with both values of the serial input. A wrong direction, a wrong fill end, or a lost fill bit therefore gives a different value. A run of left shifts that feeds in ones from an all-zero start exposes any sequential bit-to-bit update, because the number of ones must grow by exactly one per edge. Load is checked with every combination of the shift controls, including serial fill values that would leave a trace if the shift ran instead of the load. Hold is checked over several idle cycles. Two chained instances shifting right show that the bit leaving the upper stage lands in the top of the lower stage.

// File: rtl/bidir_shreg_pkg.sv
package bidir_shreg_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LEFT  = 2'd1,
    OP_RIGHT = 2'd2,
    OP_LOAD  = 2'd3
  } shOp_e;

  typedef struct packed {
    logic  clear;
    shOp_e op;
  } shStrobe_t;
endpackage

// File: rtl/bidir_shreg_ctrl.sv
module bidir_shreg_ctrl
  import bidir_shreg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      loadEn,
  input  logic      shiftEn,
  input  logic      dirRight,
  output shStrobe_t strobe
);
  always_comb begin
    strobe.clear = rst;
    if (loadEn)       strobe.op = OP_LOAD;
    else if (!shiftEn) strobe.op = OP_HOLD;
    else if (dirRight) strobe.op = OP_RIGHT;
    else               strobe.op = OP_LEFT;
  end

  // R5
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    loadEn |-> strobe.op == OP_LOAD);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!loadEn && !shiftEn) |-> strobe.op == OP_HOLD);
endmodule

// File: rtl/bidir_shreg_dp.sv
module bidir_shreg_dp
  import bidir_shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  shStrobe_t        strobe,
  input  logic             serIn,
  input  logic             dirRight,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] q,
  output logic             serOut
);
  localparam int MSB = WIDTH - 1;
  logic [WIDTH-1:0] nextQ;

  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      logic fromLow, fromHigh;
      if (b == 0) begin : g_lo
        assign fromLow = serIn;
      end else begin : g_lo
        assign fromLow = q[b-1];
      end
      if (b == MSB) begin : g_hi
        assign fromHigh = serIn;
      end else begin : g_hi
        assign fromHigh = q[b+1];
      end
      always_comb begin
        unique case (strobe.op)
          OP_LEFT:  nextQ[b] = fromLow;
          OP_RIGHT: nextQ[b] = fromHigh;
          OP_LOAD:  nextQ[b] = parIn[b];
          default:  nextQ[b] = q[b];
        endcase
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobe.clear) q <= '0;
    else              q <= nextQ;
  end

  assign serOut = dirRight ? q[0] : q[MSB];

  // R1
  reset_clear_chk: assert property (@(posedge clk) rst |=> q == '0);
  // R3
  left_fill_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.op == OP_LEFT |=> q[0] == $past(serIn) && q[MSB:1] == $past(q[MSB-1:0]));
  // R4
  right_fill_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.op == OP_RIGHT |=> q[MSB] == $past(serIn) && q[MSB-1:0] == $past(q[MSB:1]));
  // R2
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    strobe.op == OP_HOLD |=> $stable(q));
endmodule

// File: rtl/bidir_shreg.sv
module bidir_shreg
  import bidir_shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             loadEn,
  input  logic             shiftEn,
  input  logic             dirRight,
  input  logic             serIn,
  input  logic [WIDTH-1:0] parIn,
  output logic [WIDTH-1:0] q,
  output logic             serOut
);
  shStrobe_t strobe;

  bidir_shreg_ctrl u_ctrl (
    .clk(clk), .rst(rst), .loadEn(loadEn), .shiftEn(shiftEn),
    .dirRight(dirRight), .strobe(strobe)
  );

  bidir_shreg_dp #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .serIn(serIn),
    .dirRight(dirRight), .parIn(parIn), .q(q), .serOut(serOut)
  );

  // R5
  load_value_chk: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> q == $past(parIn));
endmodule

// File: tb/bidir_shreg_bench.sv
module bidir_shreg_bench;
  localparam int W = 8;
  logic clk = 0, rst = 1;
  logic loadEn = 0, shiftEn = 0, dirRight = 0, serIn = 0;
  logic [W-1:0] parIn = '0;
  logic [W-1:0] q;
  logic serOut;
  // second stage for chaining
  logic [W-1:0] qLo;
  logic serOutLo;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  bidir_shreg #(.WIDTH(W)) u_bidir_shreg (
    .clk(clk), .rst(rst), .loadEn(loadEn), .shiftEn(shiftEn),
    .dirRight(dirRight), .serIn(serIn), .parIn(parIn), .q(q), .serOut(serOut));

  bidir_shreg #(.WIDTH(W)) u_lower (
    .clk(clk), .rst(rst), .loadEn(loadEn), .shiftEn(shiftEn),
    .dirRight(dirRight), .serIn(serOut), .parIn(~parIn), .q(qLo), .serOut(serOutLo));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive inputs at negedge, clock in at posedge, sample at next negedge
  task automatic step(logic ld, logic sh, logic dr, logic si, logic [W-1:0] pi);
    loadEn = ld; shiftEn = sh; dirRight = dr; serIn = si; parIn = pi;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1; step(1, 1, 0, 1, 8'hFF);
    chk("R1", q, 8'h00);
    rst = 0;
  endtask

  task automatic t_hold();
    step(1, 0, 0, 0, 8'hB6);
    for (int i = 0; i < 3; i++) begin
      step(0, 0, i[0], 1, 8'h00);
      chk("R2", q, 8'hB6);
    end
  endtask

  task automatic t_left();
    step(1, 0, 0, 0, 8'hB6);
    step(0, 1, 0, 1, 8'h00); chk("R3", q, 8'h6D);
    step(0, 1, 0, 0, 8'h00); chk("R3", q, 8'hDA);
  endtask

  task automatic t_right();
    step(1, 0, 0, 0, 8'h81);
    step(0, 1, 1, 0, 8'h00); chk("R4", q, 8'h40);
    step(0, 1, 1, 1, 8'h00); chk("R4", q, 8'hA0);
  endtask

  task automatic t_load();
    step(1, 0, 0, 0, 8'h00);
    step(1, 1, 0, 1, 8'h3C); chk("R5", q, 8'h3C);
    step(1, 1, 1, 1, 8'hC5); chk("R5", q, 8'hC5);
  endtask

  task automatic t_simul();
    logic [W-1:0] exp;
    step(1, 0, 0, 0, 8'h00);
    exp = '0;
    for (int i = 0; i < W; i++) begin
      step(0, 1, 0, 1, 8'h00);
      exp = {exp[W-2:0], 1'b1};
      chk("R6", q, exp);
    end
    chk("R6", q, 8'hFF);
  endtask

  task automatic t_serout();
    step(1, 0, 0, 0, 8'h01);
    dirRight = 0; #1; chk("R7", serOut, 1'b0);
    dirRight = 1; #1; chk("R7", serOut, 1'b1);
    step(1, 0, 0, 0, 8'h80);
    dirRight = 0; #1; chk("R7", serOut, 1'b1);
    dirRight = 1; #1; chk("R7", serOut, 1'b0);
  endtask

  task automatic t_chain();
    logic [2*W-1:0] wide;
    step(1, 0, 1, 0, 8'hA5);  // upper A5, lower 5A
    wide = {8'hA5, 8'h5A};
    for (int i = 0; i < 3; i++) begin
      step(0, 1, 1, i[0], 8'h00);
      wide = {logic'(i[0]), wide[2*W-1:1]};
      chk("R8", {q, qLo}, wide);
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_hold();
    t_left();
    t_right();
    t_load();
    t_simul();
    t_serout();
    t_chain();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule